// File: doc/BRIEF.md
# Flash Write Suspend and Resume Controller

This block is the control logic in a serial flash device that starts long program and erase operations and decides whether a suspend or resume request is honoured while one of them runs. It takes decoded command strobes, a microsecond tick and an early-completion pulse. It reports a busy flag, two suspended-status flags and, for every command in every cycle, whether that command was accepted or ignored.

Each operation is modelled by a down-counter that is loaded with a per-type duration in microseconds. A suspend parks the running operation with its counter frozen. While the operation is parked, one more non-chip operation may run in a second slot, and a resume may continue the parked one only after that second operation has finished. Suspend requests must be spaced out in time. The spacing is measured by a saturating microsecond counter.

Top module: `wr_susp_ctrl`

## Requirements
- R1: After reset, busy_o, erase_susp_o and prog_susp_o are 0, no command is flagged, and the first suspend request is accepted without waiting for the spacing interval.
- R2: Command bit positions in cmd_acc_o and cmd_ign_o are: 0 suspend, 1 resume, 2 sector erase, 3 block erase, 4 page program, 5 quad page program, 6 chip erase. A start command is accepted only while busy_o is 0. Otherwise it is flagged ignored.
- R3: A suspend request is accepted while a sector erase, block erase, page program or quad page program is running. After that edge busy_o is 0, and erase_susp_o (for sector or block erase) or prog_susp_o (for either program) is 1. The two flags are never 1 together.
- R4: A suspend request that arrives during a chip erase is ignored, and the chip erase continues.
- R5: A suspend request that arrives while an operation is already suspended is ignored.
- R6: A chip erase command is ignored while an operation is suspended, including when nothing else is running.
- R7: A resume request is ignored while an operation started during the suspension is still running. Once that operation has finished, the resume is accepted.
- R8: A suspend request that arrives fewer than SPACING_US microsecond ticks after the previous accepted suspend is ignored. At exactly SPACING_US ticks the request is accepted.
- R9: Resume continues the parked operation with the remaining tick count and the type it had when suspended. The matching suspended flag clears and busy_o returns to 1. No ticks are consumed while the operation is parked.
- R10: An operation ends, and busy_o falls, after as many ticks as its type's duration parameter or at an op_done_i pulse, whichever comes first.
- R11: A cycle with more than one command strobe high flags all of those commands ignored and changes no state.
- R12: While an operation is suspended and nothing else runs, busy_o is 0, and a sector erase, block erase or either program is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| suspend_i | input | 1 | Suspend command strobe |
| resume_i | input | 1 | Resume command strobe |
| sect_erase_i | input | 1 | Sector erase command strobe |
| blk_erase_i | input | 1 | Block erase command strobe |
| page_prog_i | input | 1 | Page program command strobe |
| qpage_prog_i | input | 1 | Quad page program command strobe |
| chip_erase_i | input | 1 | Chip erase command strobe |
| op_done_i | input | 1 | Ends the running operation at once |
| busy_o | output | 1 | An operation is running |
| erase_susp_o | output | 1 | An erase is suspended |
| prog_susp_o | output | 1 | A program is suspended |
| cmd_acc_o | output | 7 | Per-command accept flags for the current cycle |
| cmd_ign_o | output | 7 | Per-command ignore flags for the current cycle |

## Verification
The bench builds the block with SPACING_US of 20 and durations of 40, 60, 8, 6 and 30 ticks for sector erase, block erase, page program, quad page program and chip erase. With these values a suspend can be placed one tick before and exactly at the spacing limit. A parked block erase still has a known remaining count when it resumes, so the bench can count down to the tick on which it finishes. A nested sector erase outlasts a short program, which puts the resume-blocking rule within reach in a few hundred cycles.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [2:0] {
    OP_SECT  = 3'd0,
    OP_BLK   = 3'd1,
    OP_PAGE  = 3'd2,
    OP_QPAGE = 3'd3,
    OP_CHIP  = 3'd4
  } op_kind_e;

  localparam int NCMD      = 7;
  localparam int CMD_SUSP  = 0;
  localparam int CMD_RES   = 1;
  localparam int CMD_SECT  = 2;
  localparam int CMD_BLK   = 3;
  localparam int CMD_PAGE  = 4;
  localparam int CMD_QPAGE = 5;
  localparam int CMD_CHIP  = 6;

  function automatic logic is_erase(op_kind_e k);
    return (k == OP_SECT) || (k == OP_BLK);
  endfunction

  function automatic logic is_prog(op_kind_e k);
    return (k == OP_PAGE) || (k == OP_QPAGE);
  endfunction

  // Maps an accepted start command to the kind of operation it launches.
  function automatic op_kind_e start_kind(logic [NCMD-1:0] starts);
    if (starts[CMD_BLK])   return OP_BLK;
    if (starts[CMD_PAGE])  return OP_PAGE;
    if (starts[CMD_QPAGE]) return OP_QPAGE;
    if (starts[CMD_CHIP])  return OP_CHIP;
    return OP_SECT;
  endfunction

  // Duration in microsecond ticks for each kind of operation.
  function automatic int unsigned dur_of(op_kind_e k, int unsigned d_sect,
                                         int unsigned d_blk, int unsigned d_page,
                                         int unsigned d_qpage, int unsigned d_chip);
    case (k)
      OP_BLK:   return d_blk;
      OP_PAGE:  return d_page;
      OP_QPAGE: return d_qpage;
      OP_CHIP:  return d_chip;
      default:  return d_sect;
    endcase
  endfunction

endpackage

// File: rtl/wsr_space_timer.sv
module wsr_space_timer #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic ready_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= TOP;
    else if (restart_i)            gap_q <= '0;
    else if (tick_i && gap_q != TOP) gap_q <= gap_q + 1'b1;
  end

  assign ready_o = (gap_q == TOP);

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) gap_q <= TOP);
  // R8
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ready_o);

endmodule

// File: rtl/wsr_op_slot.sv
module wsr_op_slot
  import wsr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  op_kind_e      kind_i,
  input  logic [CW-1:0] dur_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          kill_i,
  output logic          active_o,
  output op_kind_e      kind_o
);
  logic [CW-1:0] cnt_q;
  logic          active_q;
  op_kind_e      kind_q;
  logic          finish;

  assign finish = active_q && (kill_i || (run_i && tick_i && cnt_q == CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= OP_SECT;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= dur_i;
      kind_q   <= kind_i;
    end else if (finish) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && run_i && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;

  // R9
  parked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !run_i && !load_i && !kill_i) |=> ($stable(cnt_q) && $stable(kind_q)));
  // R10
  nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> dur_i != '0);

endmodule

// File: rtl/wsr_arbiter.sv
module wsr_arbiter
  import wsr_pkg::*;
(
  input  logic [NCMD-1:0] cmd_i,
  input  logic            prim_run_i,
  input  op_kind_e        prim_kind_i,
  input  logic            susp_i,
  input  logic            nest_act_i,
  input  logic            space_ready_i,
  output logic [NCMD-1:0] acc_o,
  output logic [NCMD-1:0] ign_o,
  output logic            load_prim_o,
  output logic            load_nest_o,
  output op_kind_e        load_kind_o
);
  logic            single;
  logic            busy;
  logic [NCMD-1:0] starts;

  always_comb begin
    single = ($countones(cmd_i) == 1);
    busy   = prim_run_i | nest_act_i;
    acc_o  = '0;
    if (single) begin
      acc_o[CMD_SUSP] = cmd_i[CMD_SUSP] & prim_run_i & ~nest_act_i
                        & (prim_kind_i != OP_CHIP) & space_ready_i;
      acc_o[CMD_RES]  = cmd_i[CMD_RES] & susp_i & ~nest_act_i;
      for (int k = CMD_SECT; k <= CMD_CHIP; k++) begin
        acc_o[k] = cmd_i[k] & ~busy & ~(susp_i & (k == CMD_CHIP));
      end
    end
    ign_o  = cmd_i & ~acc_o;
    starts = acc_o & ~NCMD'(3);
    load_prim_o = (starts != '0) & ~susp_i;
    load_nest_o = (starts != '0) &  susp_i;
    load_kind_o = start_kind(starts);
  end

endmodule

// File: rtl/wr_susp_ctrl.sv
module wr_susp_ctrl
  import wsr_pkg::*;
#(
  parameter int SPACING_US = 500,
  parameter int SECT_US    = 18000,
  parameter int BLK_US     = 25000,
  parameter int PAGE_US    = 750,
  parameter int QPAGE_US   = 750,
  parameter int CHIP_US    = 25000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick_i,
  input  logic        suspend_i,
  input  logic        resume_i,
  input  logic        sect_erase_i,
  input  logic        blk_erase_i,
  input  logic        page_prog_i,
  input  logic        qpage_prog_i,
  input  logic        chip_erase_i,
  input  logic        op_done_i,
  output logic        busy_o,
  output logic        erase_susp_o,
  output logic        prog_susp_o,
  output logic [6:0]  cmd_acc_o,
  output logic [6:0]  cmd_ign_o
);
  localparam int M1   = (SECT_US > BLK_US) ? SECT_US : BLK_US;
  localparam int M2   = (PAGE_US > QPAGE_US) ? PAGE_US : QPAGE_US;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXD = (M3 > CHIP_US) ? M3 : CHIP_US;
  localparam int CW   = $clog2(MAXD + 1);

  logic [NCMD-1:0] cmd;
  logic            susp_q;
  logic            prim_act, nest_act, prim_run;
  op_kind_e        prim_kind, nest_kind, load_kind;
  logic            load_prim, load_nest;
  logic            space_ready;
  logic            susp_take, res_take;
  logic [CW-1:0]   load_dur;

  assign cmd = {chip_erase_i, qpage_prog_i, page_prog_i, blk_erase_i,
                sect_erase_i, resume_i, suspend_i};

  assign prim_run = prim_act & ~susp_q;

  wsr_arbiter u_arb (
    .cmd_i        (cmd),
    .prim_run_i   (prim_run),
    .prim_kind_i  (prim_kind),
    .susp_i       (susp_q),
    .nest_act_i   (nest_act),
    .space_ready_i(space_ready),
    .acc_o        (cmd_acc_o),
    .ign_o        (cmd_ign_o),
    .load_prim_o  (load_prim),
    .load_nest_o  (load_nest),
    .load_kind_o  (load_kind)
  );

  assign susp_take = cmd_acc_o[CMD_SUSP];
  assign res_take  = cmd_acc_o[CMD_RES];
  assign load_dur  = CW'(dur_of(load_kind, SECT_US, BLK_US, PAGE_US, QPAGE_US, CHIP_US));

  wsr_op_slot #(.CW(CW)) u_prim (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_prim), .kind_i(load_kind), .dur_i(load_dur),
    .run_i(prim_run), .tick_i(us_tick_i),
    .kill_i(op_done_i & prim_run & ~nest_act),
    .active_o(prim_act), .kind_o(prim_kind)
  );

  wsr_op_slot #(.CW(CW)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_nest), .kind_i(load_kind), .dur_i(load_dur),
    .run_i(nest_act), .tick_i(us_tick_i),
    .kill_i(op_done_i & nest_act),
    .active_o(nest_act), .kind_o(nest_kind)
  );

  wsr_space_timer #(.LIMIT(SPACING_US)) u_space (
    .clk(clk), .rst_n(rst_n),
    .tick_i(us_tick_i), .restart_i(susp_take),
    .ready_o(space_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         susp_q <= 1'b0;
    else if (susp_take) susp_q <= 1'b1;
    else if (res_take)  susp_q <= 1'b0;
  end

  assign busy_o       = prim_run | nest_act;
  assign erase_susp_o = susp_q & is_erase(prim_kind);
  assign prog_susp_o  = susp_q & is_prog(prim_kind);

  // R5
  single_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_take |-> !susp_q);
  // R4
  no_chip_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_take |-> prim_kind != OP_CHIP);
  // R6
  chip_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc_o[CMD_CHIP] |-> !susp_q);
  // R7
  resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_take |-> !nest_act);
  // R3
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_susp_o, prog_susp_o}));
  // R3
  park_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_take |=> (erase_susp_o || prog_susp_o) && !busy_o);
  // R12
  nest_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_act |-> nest_kind != OP_CHIP);

endmodule

// File: tb/wr_susp_ctrl_bench.sv
`timescale 1ns/1ps
module wr_susp_ctrl_bench;
  localparam int SP = 20, D_SECT = 40, D_BLK = 60, D_PAGE = 8, D_QPAGE = 6, D_CHIP = 30;
  localparam logic [6:0] B_SUSP = 7'b0000001, B_RES = 7'b0000010, B_SECT = 7'b0000100,
                         B_BLK = 7'b0001000, B_PAGE = 7'b0010000, B_QPAGE = 7'b0100000,
                         B_CHIP = 7'b1000000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, done = 1'b0;
  logic [6:0] cmdv = '0;
  logic busy, esus, psus;
  logic [6:0] acc, ign, acc_s, ign_s;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wr_susp_ctrl #(.SPACING_US(SP), .SECT_US(D_SECT), .BLK_US(D_BLK), .PAGE_US(D_PAGE),
                 .QPAGE_US(D_QPAGE), .CHIP_US(D_CHIP)) u_wr_susp_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick_i(tick),
    .suspend_i(cmdv[0]), .resume_i(cmdv[1]), .sect_erase_i(cmdv[2]), .blk_erase_i(cmdv[3]),
    .page_prog_i(cmdv[4]), .qpage_prog_i(cmdv[5]), .chip_erase_i(cmdv[6]),
    .op_done_i(done), .busy_o(busy), .erase_susp_o(esus), .prog_susp_o(psus),
    .cmd_acc_o(acc), .cmd_ign_o(ign));

  task automatic chk(string req, string what, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmdv = '0; tick = 1'b0; done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Drive a command vector for one cycle; capture accept/ignore before the edge.
  task automatic issue(logic [6:0] v);
    @(negedge clk); cmdv = v;
    #1 acc_s = acc; ign_s = ign;
    @(posedge clk); #1 cmdv = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(posedge clk); #1 done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "busy", {6'b0, busy}, 7'd0);
    chk("R1", "erase flag", {6'b0, esus}, 7'd0);
    chk("R1", "prog flag", {6'b0, psus}, 7'd0);
    chk("R1", "accept idle", acc, 7'd0);
    chk("R1", "ignore idle", ign, 7'd0);
  endtask

  task automatic t_spacing();
    do_reset();
    issue(B_BLK);  chk("R2", "block start acc", acc_s, B_BLK);
    ticks(5);
    issue(B_SUSP); chk("R1", "first suspend acc", acc_s, B_SUSP);
    chk("R3", "erase flag", {6'b0, esus}, 7'd1);
    chk("R3", "prog flag", {6'b0, psus}, 7'd0);
    chk("R3", "busy parked", {6'b0, busy}, 7'd0);
    issue(B_RES);  chk("R9", "resume acc", acc_s, B_RES);
    chk("R9", "erase flag cleared", {6'b0, esus}, 7'd0);
    chk("R9", "busy again", {6'b0, busy}, 7'd1);
    ticks(SP - 1);
    issue(B_SUSP); chk("R8", "early suspend ign", ign_s, B_SUSP);
    chk("R8", "early suspend no flag", {6'b0, esus}, 7'd0);
    ticks(1);
    issue(B_SUSP); chk("R8", "suspend at limit acc", acc_s, B_SUSP);
    ticks(50);
    chk("R9", "frozen parked busy", {6'b0, busy}, 7'd0);
    chk("R9", "still parked", {6'b0, esus}, 7'd1);
    issue(B_RES);
    ticks(D_BLK - 5 - SP - 1);
    chk("R9", "remaining time kept", {6'b0, busy}, 7'd1);
    ticks(1);
    chk("R10", "block finished", {6'b0, busy}, 7'd0);
  endtask

  task automatic t_nested();
    do_reset();
    issue(B_PAGE); chk("R2", "page start acc", acc_s, B_PAGE);
    ticks(2);
    issue(B_SUSP); chk("R3", "suspend page acc", acc_s, B_SUSP);
    chk("R3", "prog flag", {6'b0, psus}, 7'd1);
    chk("R12", "busy low parked", {6'b0, busy}, 7'd0);
    issue(B_SECT); chk("R12", "nested sector acc", acc_s, B_SECT);
    chk("R12", "busy nested", {6'b0, busy}, 7'd1);
    issue(B_RES);  chk("R7", "resume during nested ign", ign_s, B_RES);
    issue(B_SUSP); chk("R5", "second suspend ign", ign_s, B_SUSP);
    issue(B_CHIP); chk("R6", "chip while nested ign", ign_s, B_CHIP);
    ticks(D_SECT);
    chk("R7", "nested done", {6'b0, busy}, 7'd0);
    chk("R7", "still parked", {6'b0, psus}, 7'd1);
    issue(B_CHIP); chk("R6", "chip while parked ign", ign_s, B_CHIP);
    chk("R6", "chip no start", {6'b0, busy}, 7'd0);
    issue(B_RES);  chk("R7", "resume after nested acc", acc_s, B_RES);
    chk("R9", "prog flag cleared", {6'b0, psus}, 7'd0);
    ticks(D_PAGE - 3);
    chk("R9", "page still running", {6'b0, busy}, 7'd1);
    ticks(1);
    chk("R9", "page finished", {6'b0, busy}, 7'd0);
  endtask

  task automatic t_chip();
    do_reset();
    issue(B_CHIP); chk("R2", "chip start acc", acc_s, B_CHIP);
    issue(B_SUSP); chk("R4", "suspend chip ign", ign_s, B_SUSP);
    chk("R4", "no flag", {5'b0, esus, psus}, 7'd0);
    issue(B_PAGE); chk("R2", "start while busy ign", ign_s, B_PAGE);
    ticks(D_CHIP - 1);
    chk("R10", "chip running", {6'b0, busy}, 7'd1);
    ticks(1);
    chk("R10", "chip finished", {6'b0, busy}, 7'd0);
  endtask

  task automatic t_done_multi();
    do_reset();
    issue(B_QPAGE); chk("R2", "qpage start acc", acc_s, B_QPAGE);
    pulse_done();
    chk("R10", "done pulse ends op", {6'b0, busy}, 7'd0);
    issue(B_SECT | B_PAGE); chk("R11", "multi start ign", ign_s, B_SECT | B_PAGE);
    chk("R11", "multi start no acc", acc_s, 7'd0);
    chk("R11", "multi no busy", {6'b0, busy}, 7'd0);
    issue(B_QPAGE);
    issue(B_SUSP | B_RES); chk("R11", "multi susp ign", ign_s, B_SUSP | B_RES);
    chk("R11", "multi keeps running", {6'b0, busy}, 7'd1);
    issue(B_SUSP); chk("R3", "qpage suspend acc", acc_s, B_SUSP);
    chk("R3", "qpage prog flag", {6'b0, psus}, 7'd1);
  endtask

  initial begin
    t_reset();
    t_spacing();
    t_nested();
    t_chip();
    t_done_multi();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule